// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block lets a processor use an external pseudo-static RAM as if it were a simple on-chip word memory. The requester places an address, a direction bit and write data on its side and raises a start strobe for one clock. The controller then runs one complete asynchronous single-word cycle on the memory pins. After reset it first waits out the memory's power-up period, and it refuses all requests during that time.

All cycle timing is counted in ticks of a base timer that is divided down from the system clock. The default is one 10 ns tick per clock at 100 MHz. A read holds the chip and output selects active for the array access time, captures the bus at the end of that window, and then recovers. A write drives the shared bidirectional data bus and pulses the write select. The write select is raised one tick before the bus is released. Every access keeps the controller busy for a full cycle period, so requests can never come closer together than the memory allows.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, `busy` is high, the chip, output and write selects are high (inactive) and the data bus is released for PWRUP_TICKS ticks. A strobe in that period starts no access. `busy` falls after exactly PWRUP_TICKS ticks.
- R2: All durations are whole numbers of base-timer ticks, and one tick is CLK_PER_TICK clocks (default 1).
- R3: A strobe with `usr_we`=0 starts a read. `mem_ce_n` and `mem_oe_n` go low for ACC_TICKS ticks (default 7), and `mem_we_n` stays high. At the end of that window the bus word is captured onto `usr_rdata`, which then holds its value until the next read completes, writes included.
- R4: A strobe with `usr_we`=1 starts a write. `mem_we_n` goes low for ACC_TICKS ticks while `usr_wdata` is driven on `mem_dq`. The bus still carries that word in the tick after `mem_we_n` rises, and `mem_ce_n` stays low through that hold tick.
- R5: `mem_dq` is driven only during a write's active and hold ticks. At all other times it is high-impedance, and `mem_oe_n` and `mem_we_n` are never low together.
- R6: Each access keeps `busy` high for CYC_TICKS ticks (default 10), counted from the clock edge that samples the strobe. A strobe while `busy` is high is ignored and changes neither the memory nor the address.
- R7: `mem_clk` and `mem_cre` are always 0 and `mem_adv_n` is always 0. `mem_lb_n` and `mem_ub_n` are low exactly while `mem_ce_n` is low, so every transfer is a full 16-bit word.
- R8: The `mem_wait` input has no effect: access lengths and data are the same whatever its level.
- R9: While idle with the strobe low, all selects stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usr_addr | input | ADDR_W | Word address of the request |
| usr_we | input | 1 | 1 = write, 0 = read, sampled with the strobe |
| usr_wdata | input | DATA_W | Word to write |
| usr_go | input | 1 | One-clock start strobe |
| usr_rdata | output | DATA_W | Last word read |
| busy | output | 1 | High unless idle after power-up |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_clk | output | 1 | Memory clock, held low |
| mem_adv_n | output | 1 | Address valid, held active (low) |
| mem_cre | output | 1 | Configuration-register select, held low |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write select, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq | inout | DATA_W | Shared data bus |
| mem_wait | input | 1 | Memory wait line, unused in this mode |

## Verification
The in-RTL properties watch the pin rules on every cycle. They check that the output and write selects never overlap, that the bus is driven only in write states and is still driven when the write select rises, that the power-up state always reports busy, that a strobe during busy leaves the address untouched, and that the wait line never stalls a read. The exact pulse lengths, the full busy period, whether data really lands in and returns from the memory, the ignored strobes, and the stability of read data across writes can only be shown by the bench. It does this with its memory model and scoreboard over write, read, overlap and wait-asserted scenarios.

// File: rtl/psram_pkg.sv
package psram_pkg;
    typedef enum logic [2:0] {
        PS_INIT,
        PS_IDLE,
        PS_RD,
        PS_WR,
        PS_WHOLD,
        PS_REC
    } psram_state_e;
endpackage

// File: rtl/psram_tick_gen.sv
module psram_tick_gen #(
    parameter int CLK_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_PER_TICK - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick  = (div_q == DIV_TOP);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: the divider never passes its terminal count
    p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_TOP);
endmodule

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = load_val;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
        expired = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    // R2: without a load the count only moves down, one step per tick
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(tick)) |-> $stable(cnt_q));
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W       = 23,
    parameter int DATA_W       = 16,
    parameter int CLK_PER_TICK = 1,
    parameter int PWRUP_TICKS  = 15000,
    parameter int ACC_TICKS    = 7,
    parameter int HOLD_TICKS   = 1,
    parameter int CYC_TICKS    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic              usr_we,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic              usr_go,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_clk,
    output logic              mem_adv_n,
    output logic              mem_cre,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [DATA_W-1:0] mem_dq,
    input  logic              mem_wait
);
    localparam int RD_REC  = CYC_TICKS - ACC_TICKS;
    localparam int WR_REC  = CYC_TICKS - ACC_TICKS - HOLD_TICKS;
    localparam int MAX_CNT = (PWRUP_TICKS > CYC_TICKS) ? PWRUP_TICKS : CYC_TICKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        psram_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              ben_n;
        logic              drive;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             tick, expired, t_load, step;
    logic [CNT_W-1:0] t_val;

    psram_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    psram_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_TICKS - 1)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (t_load),
        .load_val(t_val),
        .expired (expired)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        step   = tick && expired;
        unique case (r_q.state)
            PS_INIT: begin
                if (step) r_d.state = PS_IDLE;
            end
            PS_IDLE: begin
                if (usr_go) begin
                    r_d.addr  = usr_addr;
                    r_d.wdata = usr_wdata;
                    r_d.state = usr_we ? PS_WR : PS_RD;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(ACC_TICKS - 1);
                end
            end
            PS_RD: begin
                if (step) begin
                    r_d.rdata = mem_dq;
                    r_d.state = PS_REC;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(RD_REC - 1);
                end
            end
            PS_WR: begin
                if (step) begin
                    r_d.state = PS_WHOLD;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(HOLD_TICKS - 1);
                end
            end
            PS_WHOLD: begin
                if (step) begin
                    r_d.state = PS_REC;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(WR_REC - 1);
                end
            end
            PS_REC: begin
                if (step) r_d.state = PS_IDLE;
            end
            default: r_d.state = PS_INIT;
        endcase
        r_d.ce_n  = !(r_d.state inside {PS_RD, PS_WR, PS_WHOLD});
        r_d.oe_n  = (r_d.state != PS_RD);
        r_d.we_n  = (r_d.state != PS_WR);
        r_d.ben_n = !(r_d.state inside {PS_RD, PS_WR, PS_WHOLD});
        r_d.drive = (r_d.state inside {PS_WR, PS_WHOLD});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= PS_INIT;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.ben_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_dq    = r_q.drive ? r_q.wdata : {DATA_W{1'bz}};
    assign usr_rdata = r_q.rdata;
    assign busy      = (r_q.state != PS_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_clk   = 1'b0;
    assign mem_adv_n = 1'b0;
    assign mem_cre   = 1'b0;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_lb_n  = r_q.ben_n;
    assign mem_ub_n  = r_q.ben_n;

    // R5: output and write selects never active together
    p_sel_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R5: bus driven only while no read output is enabled
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !r_q.drive);
    // R4: the data is still on the bus when the write select rises
    p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (r_q.drive && !mem_ce_n));
    // R1: power-up state always reports busy with selects inactive
    p_init_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_INIT) |-> (busy && mem_ce_n));
    // R6: a strobe while busy leaves the address untouched
    p_ignore_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && usr_go) |=> $stable(mem_addr));
    // R8: the wait line never stalls the end of a read window
    p_wait_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RD && mem_wait && tick && expired) |=> (r_q.state == PS_REC));
    // R9: idle with no strobe keeps the chip deselected
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !usr_go) |=> mem_ce_n);
endmodule

// File: tb/tb_psram_async_ctrl.sv
module tb_psram_async_ctrl;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam int PW = 15000;

    typedef struct {
        bit          rd;
        bit          wr;
        logic [15:0] val;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic          usr_we = 1'b0;
    logic [DW-1:0] usr_wdata = '0;
    logic          usr_go = 1'b0;
    logic [DW-1:0] usr_rdata;
    logic          busy;
    logic [AW-1:0] mem_addr;
    logic          mem_clk, mem_adv_n, mem_cre, mem_ce_n, mem_oe_n, mem_we_n;
    logic          mem_lb_n, mem_ub_n;
    wire  [DW-1:0] mem_dq;
    logic          mem_wait = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] marr [0:255];
    logic [15:0] shadow [0:255];
    exp_t q[$];

    always #5 clk = ~clk;

    psram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_we(usr_we),
        .usr_wdata(usr_wdata), .usr_go(usr_go), .usr_rdata(usr_rdata), .busy(busy),
        .mem_addr(mem_addr), .mem_clk(mem_clk), .mem_adv_n(mem_adv_n), .mem_cre(mem_cre),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq(mem_dq), .mem_wait(mem_wait)
    );

    // memory model
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? marr[mem_addr[7:0]] : 16'hzzzz;
    always @(posedge mem_we_n) if (!mem_ce_n) marr[mem_addr[7:0]] = mem_dq;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit we, logic [AW-1:0] a, logic [15:0] dat);
        exp_t e;
        e.rd = !we; e.wr = we; e.val = we ? dat : shadow[a[7:0]];
        if (we) shadow[a[7:0]] = dat;
        q.push_back(e);
        usr_addr = a; usr_we = we; usr_wdata = dat; usr_go = 1'b1;
        @(negedge clk); usr_go = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 lb", 32'(mem_lb_n), 0);
        chk("R7 ub", 32'(mem_ub_n), 0);
        chk("R7 pins", {29'd0, mem_clk, mem_cre, mem_adv_n}, 0);
        if (we) chk("R4 data on bus", 32'(mem_dq), 32'(dat));
        else    chk("R3 oe low", 32'(mem_oe_n), 0);
        while (busy) @(negedge clk);
    endtask

    // monitor / scoreboard
    int  bcnt = 0, ccnt = 0, wcnt = 0, ocnt = 0;
    bit  bprev = 1'b1, weprev = 1'b1, init_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (weprev == 1'b0 && mem_we_n == 1'b1 && q.size() > 0)
                chk("R4 hold after we rise", 32'(mem_dq), 32'(q[0].val));
            if (bprev && !busy) begin
                if (!init_done) init_done = 1'b1;
                else if (q.size() == 0) chk("R6 unexpected access", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R6 busy ticks", bcnt, 10);
                    chk("R3/R4 ce ticks", ccnt, e.wr ? 8 : 7);
                    if (e.rd) begin
                        chk("R3 oe ticks", ocnt, 7);
                        chk("R3 read data", 32'(usr_rdata), 32'(e.val));
                    end else begin
                        chk("R4 we ticks", wcnt, 7);
                    end
                end
                bcnt = 0; ccnt = 0; wcnt = 0; ocnt = 0;
            end
            if (busy && init_done) bcnt++;
            if (!mem_ce_n) ccnt++;
            if (!mem_we_n) wcnt++;
            if (!mem_oe_n) ocnt++;
            bprev = busy;
            weprev = mem_we_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        for (int i = 0; i < 256; i++) begin
            marr[i] = 16'(i * 16'h0101) ^ 16'h3C00;
            shadow[i] = marr[i];
        end
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 1);
        chk("R1 ce in reset", 32'(mem_ce_n), 1);
        chk("R1 we/oe in reset", {30'd0, mem_we_n, mem_oe_n}, 3);
        chk("R5 bus released in reset", 32'(mem_dq === 16'hzzzz), 1);
        rst_n = 1'b1; usr_we = 1'b1; usr_wdata = 16'hBEEF; usr_go = 1'b1;
        @(negedge clk); usr_go = 1'b0;
        @(negedge clk);
        chk("R1 strobe ignored in init", {30'd0, mem_ce_n, mem_we_n}, 3);
        repeat (PW - 3) @(negedge clk);
        chk("R1 busy before power-up end", 32'(busy), 1);
        @(negedge clk);
        chk("R1 ready at power-up end", 32'(busy), 0);
        chk("R7 idle pins", {27'd0, mem_clk, mem_cre, mem_adv_n, mem_lb_n, mem_ub_n}, 3);
        chk("R5 idle bus z", 32'(mem_dq === 16'hzzzz), 1);
        chk("R1 init strobe wrote nothing", 32'(marr[0]), 32'(shadow[0]));

        access(1, 23'd5, 16'hA5A5);
        access(1, 23'd0, 16'h0000);
        access(1, 23'd255, 16'hFFFF);
        access(1, 23'd17, 16'h1234);
        access(0, 23'd5, 16'h0);
        hold = usr_rdata;
        access(1, 23'd9, 16'h5A5A);
        chk("R3 rdata stable across write", 32'(usr_rdata), 32'(hold));
        access(0, 23'd0, 16'h0);
        access(0, 23'd255, 16'h0);
        access(0, 23'd17, 16'h0);
        access(0, 23'd100, 16'h0);

        // strobe during a busy read is ignored
        begin
            exp_t e;
            e.rd = 1; e.wr = 0; e.val = shadow[5];
            q.push_back(e);
            usr_addr = 23'd5; usr_we = 1'b0; usr_go = 1'b1;
            @(negedge clk); usr_go = 1'b0;
            repeat (2) @(negedge clk);
            usr_addr = 23'd200; usr_we = 1'b1; usr_wdata = 16'hDEAD; usr_go = 1'b1;
            @(negedge clk); usr_go = 1'b0;
            chk("R6 address kept", 32'(mem_addr), 5);
            while (busy) @(negedge clk);
        end
        access(0, 23'd200, 16'h0);

        // wait line high has no effect
        mem_wait = 1'b1;
        access(1, 23'd33, 16'h0F0F);
        access(0, 23'd33, 16'h0);
        mem_wait = 1'b0;
        chk("R8 stored with wait high", 32'(marr[33]), 32'h0F0F);

        usr_go = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 idle selects", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk("R9 idle busy", 32'(busy), 0);
        chk("R6 queue drained", q.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule